// File: doc/BRIEF.md
# Conversion Result Buffer with Watermark Interrupt

This block sits between a converter that produces results without pause and the host-side interface logic. Each completed result arrives as a single-cycle strobe with its data word and is stored in order. The host is free to sleep while results pile up. It is woken by an interrupt once a programmable number of results is waiting, and it then reads the buffer out in a burst.

The interrupt does not follow the fill level down. It is set once the stored count reaches the watermark and stays set until the buffer has been read completely empty. Results that arrive during the burst are still accepted. A read and a write may happen in the same cycle, including when the buffer is full. A result that finds the buffer full with no read in that cycle is dropped, and a sticky loss flag records it so that the host can tell the stream has a gap. The occupancy is reported on a count output wide enough to hold the full depth.

Top module: `result_fifo_irq`

## Requirements
- R1: After reset `count`, `irq`, `ovf` and `rd_data` are all 0.
- R2: A `wr_valid` strobe while `count` < DEPTH (256) stores `wr_data` and raises `count` by 1 at the next edge. Stored words are returned in arrival order.
- R3: A `rd_req` while `count` > 0 places the oldest stored word on `rd_data` one cycle later and lowers `count` by 1.
- R4: A `rd_req` while `count` = 0 drives `rd_data` to 0 one cycle later and leaves `count` unchanged.
- R5: A read and a write in the same cycle with `count` > 0 leave `count` unchanged and both take effect. This includes the full case, where the write is accepted because the read frees a slot.
- R6: A `wr_valid` strobe while `count` = 256 with no `rd_req` drops the word, leaves `count` at 256, and sets `ovf` at the next edge. `ovf` then stays set.
- R7: `ovf_clr` clears `ovf` at the next edge unless a drop happens in the same cycle, in which case `ovf` stays 1.
- R8: `irq` becomes 1 in the same cycle that `count` first shows a value ≥ `wm_level` (with `count` > 0). It stays 1 while reads lower `count` below the watermark, as long as `count` > 0.
- R9: `irq` is 0 in every cycle in which `count` is 0, so it clears in the cycle the buffer becomes empty.
- R10: A watermark of 256 raises `irq` only when `count` reaches 256, and not at 255. A watermark of 0 raises `irq` as soon as any word is stored.
- R11: Writes that arrive while the host is draining the buffer are stored and read back in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | One-cycle strobe for a finished conversion result |
| wr_data | input | DATA_W | Result word to store |
| rd_req | input | 1 | Host read request, one word per cycle |
| rd_data | output | DATA_W | Word read out, valid the cycle after `rd_req`; 0 if the buffer was empty |
| wm_level | input | $clog2(DEPTH)+1 | Watermark count that raises the interrupt |
| ovf_clr | input | 1 | Clears the sticky loss flag |
| count | output | $clog2(DEPTH)+1 | Number of stored words, 0 to DEPTH |
| irq | output | 1 | Watermark interrupt, held until the buffer is empty |
| ovf | output | 1 | Sticky flag: a result was dropped on a full buffer |

## Verification
The bound checker watches the cycle-level rules on every clock:
- how the count moves for a lone write, a lone read, and a paired read and write;
- that a full buffer holds its level and flags the loss;
- that the loss flag persists until cleared, and that a clear takes effect;
- that the empty-read value is zero;
- that the interrupt is tied to the count, both while it is raised and when it is released.

Only the bench scenarios can show that data comes back in order, including words written during a drain. They also show that the interrupt holds while the count falls below the watermark, the 255 versus 256 boundary of the largest watermark, and the clear colliding with a drop.

// File: rtl/rfifo_pkg.sv
// Package rfifo_pkg
// Shared types for the result buffer. The transfer struct carries the
// per-cycle decisions that the control block makes, to the storage and
// flag blocks.
package rfifo_pkg;

    // Per-cycle transfer decision: accepted write, real read, lost write
    typedef struct packed {
        logic push;
        logic pop;
        logic drop;
    } rfifo_xfer_t;

endpackage

// File: rtl/rfifo_ctrl.sv
// Module rfifo_ctrl
// Pointer and occupancy control for the result buffer. It decides each
// cycle whether a write is accepted, a read is served or a write is lost.
// Assumes DEPTH is a power of two, so that the pointers wrap naturally.
// A read on a full buffer frees the slot that a same-cycle write takes.
module rfifo_ctrl
    import rfifo_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    input  logic                     rd_req,
    output rfifo_xfer_t              xfer,
    output logic [$clog2(DEPTH)-1:0] wptr,
    output logic [$clog2(DEPTH)-1:0] rptr,
    output logic [$clog2(DEPTH):0]   count,
    output logic [$clog2(DEPTH):0]   count_next
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic empty;
    logic full;

    // Decide the transfer for this cycle from occupancy and requests
    always_comb begin
        empty     = (count == '0);
        full      = (count == FULL_LVL);
        xfer.pop  = rd_req && !empty;
        xfer.push = wr_valid && (!full || xfer.pop);
        xfer.drop = wr_valid && full && !xfer.pop;
    end

    // Next occupancy from the accepted write and served read
    always_comb begin
        count_next = count;
        if (xfer.push && !xfer.pop) begin
            count_next = count + CW'(1);
        end else if (xfer.pop && !xfer.push) begin
            count_next = count - CW'(1);
        end
    end

    // Advance the pointers and the occupancy register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (xfer.push) begin
                wptr <= wptr + AW'(1);
            end
            if (xfer.pop) begin
                rptr <= rptr + AW'(1);
            end
            count <= count_next;
        end
    end

endmodule

// File: rtl/rfifo_store.sv
// Module rfifo_store
// Word storage with a registered read port. A read on the same address
// as a write returns the old word, which is the word leaving a full
// buffer. A read request on an empty buffer loads zero. The array has
// no reset; only the output register is reset.
module rfifo_store
    import rfifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  rfifo_xfer_t              xfer,
    input  logic                     rd_req,
    input  logic [$clog2(DEPTH)-1:0] wptr,
    input  logic [$clog2(DEPTH)-1:0] rptr,
    input  logic [DATA_W-1:0]        wr_data,
    output logic [DATA_W-1:0]        rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    // Write an accepted result into the array
    always_ff @(posedge clk) begin
        if (xfer.push) begin
            mem[wptr] <= wr_data;
        end
    end

    // Load the output register on each read request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (xfer.pop) begin
            rd_data <= mem[rptr];
        end else if (rd_req) begin
            rd_data <= '0;
        end
    end

endmodule

// File: rtl/rfifo_flags.sv
// Module rfifo_flags
// Watermark interrupt and sticky loss flag. The interrupt is set from the
// next occupancy, so it appears in the same cycle as the count that
// reaches the watermark. It is released only at zero occupancy. A loss
// in the same cycle as a clear keeps the flag set.
module rfifo_flags
    import rfifo_pkg::*;
#(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  rfifo_xfer_t   xfer,
    input  logic [CW-1:0] count_next,
    input  logic [CW-1:0] wm_level,
    input  logic          ovf_clr,
    output logic          irq,
    output logic          ovf
);

    // Interrupt: release at empty, set at or above the watermark, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (count_next == '0) begin
            irq <= 1'b0;
        end else if (count_next >= wm_level) begin
            irq <= 1'b1;
        end
    end

    // Loss flag: a drop sets it, a clear without a drop resets it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else begin
            ovf <= xfer.drop || (ovf && !ovf_clr);
        end
    end

endmodule

// File: rtl/result_fifo_irq.sv
// Module result_fifo_irq
// Buffer for conversion results with a watermark interrupt and loss
// reporting. The clock is single; writes and reads may coincide. The
// interrupt is held until the buffer is empty. Assumes DEPTH is a power
// of two.
module result_fifo_irq
    import rfifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_valid,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   rd_req,
    output logic [DATA_W-1:0]      rd_data,
    input  logic [$clog2(DEPTH):0] wm_level,
    input  logic                   ovf_clr,
    output logic [$clog2(DEPTH):0] count,
    output logic                   irq,
    output logic                   ovf
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    rfifo_xfer_t   xfer;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] count_next;

    rfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .rd_req     (rd_req),
        .xfer       (xfer),
        .wptr       (wptr),
        .rptr       (rptr),
        .count      (count),
        .count_next (count_next)
    );

    rfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .xfer    (xfer),
        .rd_req  (rd_req),
        .wptr    (wptr),
        .rptr    (rptr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    rfifo_flags #(.CW(CW)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer       (xfer),
        .count_next (count_next),
        .wm_level   (wm_level),
        .ovf_clr    (ovf_clr),
        .irq        (irq),
        .ovf        (ovf)
    );

endmodule

// File: rtl/rfifo_chk.sv
// Module rfifo_chk
// Port-level checker for result_fifo_irq. It is bound to every instance
// of the top module. It sees only the top-level ports.
module rfifo_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_valid,
    input logic                   rd_req,
    input logic                   ovf_clr,
    input logic [$clog2(DEPTH):0] wm_level,
    input logic [$clog2(DEPTH):0] count,
    input logic                   irq,
    input logic                   ovf,
    input logic [DATA_W-1:0]      rd_data
);

    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    // R2: a lone write below full adds one
    assert_write_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !rd_req && count != FULL_LVL) |=> (count == $past(count) + CW'(1)));

    // R2: occupancy never exceeds the depth
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_LVL);

    // R3: a lone read on a non-empty buffer removes one
    assert_read_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !wr_valid && count != '0) |=> (count == $past(count) - CW'(1)));

    // R4: a read on an empty buffer returns zero
    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && count == '0) |=> (rd_data == '0));

    // R5: a paired read and write keep the level
    assert_pair_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_valid && count != '0) |=> (count == $past(count)));

    // R6: a write into a full buffer is lost and flagged
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !rd_req && count == FULL_LVL) |=> (count == FULL_LVL && ovf));

    // R6: the loss flag is sticky without a clear
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf);

    // R7: a clear with no drop in the same cycle releases the flag
    assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !(wr_valid && !rd_req && count == FULL_LVL)) |=> !ovf);

    // R8: at or above a steady watermark with data stored, irq is high
    assert_irq_at_wm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (count >= wm_level && count != '0 && wm_level == $past(wm_level)) |-> irq);

    // R9: no interrupt on an empty buffer
    assert_irq_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> !irq);

    // R9: the interrupt falls only when the buffer is empty
    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> (count == '0));

endmodule

bind result_fifo_irq rfifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rfifo_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .rd_req   (rd_req),
    .ovf_clr  (ovf_clr),
    .wm_level (wm_level),
    .count    (count),
    .irq      (irq),
    .ovf      (ovf),
    .rd_data  (rd_data)
);

// File: tb/tb_result_fifo_irq.sv
// Scoreboard bench for result_fifo_irq: the driver task keeps a queue of
// expected words and expected flag values; the monitor compares them on
// the falling edge after each clocked step.
module tb_result_fifo_irq;

    localparam int DATA_W = 16;
    localparam int DEPTH  = 256;
    localparam int CW     = $clog2(DEPTH) + 1;
    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              rd_req = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic [CW-1:0]     wm_level = CW'(4);
    logic              ovf_clr = 1'b0;
    logic [CW-1:0]     count;
    logic              irq;
    logic              ovf;

    int checks = 0;
    int fails  = 0;

    // Model state (updated by the driver)
    logic [DATA_W-1:0] sb_q[$];
    bit                m_irq = 1'b0;
    bit                m_ovf = 1'b0;
    logic [DATA_W-1:0] next_dat = 16'h0A51;

    // Snapshot for the monitor
    bit                mon_chk = 1'b0;
    bit                mon_rd = 1'b0;
    int                mon_cnt = 0;
    bit                mon_irq = 1'b0;
    bit                mon_ovf = 1'b0;
    logic [DATA_W-1:0] mon_rd_exp = '0;
    string             mon_tag = "";

    always #(CLK_PERIOD / 2) clk = ~clk;

    result_fifo_irq #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_req   (rd_req),
        .rd_data  (rd_data),
        .wm_level (wm_level),
        .ovf_clr  (ovf_clr),
        .count    (count),
        .irq      (irq),
        .ovf      (ovf)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: one clock step with the given requests, updating the model
    task automatic step(input bit wr, input bit rd, input bit clr, input string tag);
        bit pop;
        bit full;
        bit drop;
        logic [DATA_W-1:0] exp_rd;
        @(negedge clk);
        wr_valid = wr;
        rd_req   = rd;
        ovf_clr  = clr;
        wr_data  = next_dat;
        full   = (sb_q.size() == DEPTH);
        pop    = rd && (sb_q.size() > 0);
        drop   = wr && full && !pop;
        exp_rd = '0;
        if (pop) exp_rd = sb_q.pop_front();
        if (wr && !drop) sb_q.push_back(next_dat);
        if (wr) next_dat = next_dat + 16'h1357;
        m_ovf = drop || (m_ovf && !clr);
        if (sb_q.size() == 0) m_irq = 1'b0;
        else if (sb_q.size() >= int'(wm_level)) m_irq = 1'b1;
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
        rd_req   = 1'b0;
        ovf_clr  = 1'b0;
        mon_cnt    = sb_q.size();
        mon_irq    = m_irq;
        mon_ovf    = m_ovf;
        mon_rd     = rd;
        mon_rd_exp = exp_rd;
        mon_tag    = tag;
        mon_chk    = 1'b1;
    endtask

    // Monitor: compare outputs against the snapshot after each step
    always @(negedge clk) begin
        if (mon_chk) begin
            check(mon_tag, "count", int'(count), mon_cnt);
            check(mon_tag, "irq", int'(irq), int'(mon_irq));
            check(mon_tag, "ovf", int'(ovf), int'(mon_ovf));
            if (mon_rd) check(mon_tag, "rd_data", int'(rd_data), int'(mon_rd_exp));
            mon_chk = 1'b0;
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "count", int'(count), 0);
        check("R1", "irq", int'(irq), 0);
        check("R1", "ovf", int'(ovf), 0);
        check("R1", "rd_data", int'(rd_data), 0);

        // R8 / R9 / R4 with watermark 4
        wm_level = CW'(4);
        for (int i = 0; i < 4; i++) step(1, 0, 0, "R8");
        step(0, 1, 0, "R3");
        step(0, 1, 0, "R8");
        step(0, 1, 0, "R8");
        step(0, 1, 0, "R9");
        step(0, 1, 0, "R4");
        step(0, 1, 0, "R4");

        // R2 / R5 paired read and write
        step(1, 0, 0, "R2");
        step(1, 0, 0, "R2");
        for (int i = 0; i < 5; i++) step(1, 1, 0, "R5");
        step(0, 1, 0, "R3");
        step(0, 1, 0, "R9");

        // R10 / R6 / R5 at watermark 256
        wm_level = CW'(256);
        for (int i = 0; i < 255; i++) step(1, 0, 0, "R10");
        step(1, 0, 0, "R10");
        step(1, 0, 0, "R6");
        step(1, 0, 0, "R6");
        step(1, 1, 0, "R5");
        // R11: drain with writes arriving
        for (int i = 0; i < 400; i++) step(i % 3 == 0, 1, 0, "R11");
        for (int i = 0; i < 4; i++) step(0, 1, 0, "R9");
        step(0, 0, 1, "R7");

        // R7: clear colliding with a drop
        for (int i = 0; i < 256; i++) step(1, 0, 0, "R2");
        step(1, 0, 1, "R7");
        step(0, 0, 1, "R7");
        for (int i = 0; i < 256; i++) step(0, 1, 0, "R3");
        step(0, 1, 0, "R9");

        // R10: watermark 0
        wm_level = '0;
        step(1, 0, 0, "R10");
        step(0, 1, 0, "R9");

        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule